// File: doc/BRIEF.md
# Serial-Loaded Wiper Code Register with Chain Output

This block is the digital control path of a 256-step digitally set resistor. A three-wire serial slave (serial clock, active-low select, data in) shifts bits into an input shift register while select is low. The rising edge of select copies that register into a wiper latch. The latch drives a one-hot tap-select bus for the resistor ladder and is also available as a binary code.

A serial output returns the bits shifted in eight serial clocks earlier, so several devices can share one select line in a chain. The output is modelled as an open-drain pin: a pull-down enable, plus a resolved level that reads high when released.

All serial pins are sampled by a fast system clock, and their edges are detected in that domain. The serial clock must therefore stay in each level for at least three system clocks.

Top module: `serialWiperTop`

## Requirements
- R1: On each rising serial-clock edge while select is low, the data-in bit is shifted into the input register, most significant bit first. After eight clocks, the first bit sent has weight 128 and the last bit sent has weight 1.
- R2: The wiper code changes only on a rising edge of select. While bits are being shifted, the latched code stays at its previous value.
- R3: When more than eight bits are clocked in within one select window, only the last eight bits received are latched. The earlier leading bits are discarded.
- R4: After reset, the wiper code is 0x80, the input register holds 0x80 and the serial output is released (level 1, pull-down 0).
- R5: The tap-select bus has exactly one line high, at the index equal to the wiper code. Code 0x00 selects line 0 (the B end) and code 0xFF selects line 255.
- R6: The serial output changes on falling serial-clock edges while select is low. After the k-th falling edge, with k of 8 or more, it carries the bit received on the (k-7)-th rising edge. In a 16-bit frame sent through two chained devices, the first byte ends up in the far device and the second byte in the near device.
- R7: The pull-down enable is high exactly when the output bit is 0, and the resolved level reads 1 whenever the pin is released.
- R8: Serial-clock edges while select is high change neither the input register nor the serial output.
- R9: A select window with no serial clocks reloads the latch from the unchanged input register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| csN | input | 1 | Active-low select; its rising edge loads the wiper latch |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdoPullDn | output | 1 | Open-drain pull-down enable for the chain output |
| sdoLevel | output | 1 | Resolved chain output level, 1 when released |
| wiperCode | output | CODE_W | Latched wiper code |
| tapSel | output | 2**CODE_W | One-hot tap-select bus |

## Verification
A corrupted input register is not visible on the wiper code until the next rising edge of select. Within the same window it shows up earlier, on the serial output, eight falling edges after the bad bit entered. For that reason the chain test compares the serial output on every falling edge from the eighth onward, and then checks the far device's latch. A wrong latch value or a broken decoder shows up at once on the code and tap buses: the checker ties the single high tap line to the code, and allows the code to change only in the cycle after a select rise.

// File: rtl/serialWiperPkg.sv
package serialWiperPkg;

  // Strobes from the edge-detect control into the datapath, one system cycle wide.
  typedef struct packed {
    logic shiftEn;    // rising serial clock while selected
    logic outUpdate;  // falling serial clock while selected
    logic latchLoad;  // rising select
  } wiperStrobes_t;

endpackage

// File: rtl/serialWiperCtrl.sv
module serialWiperCtrl
  import serialWiperPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclk,
  input  logic          csN,
  input  logic          sdi,
  output wiperStrobes_t strobes,
  output logic          sdiBit
);

  logic sclkQ, sclkPrev;
  logic csNQ, csNPrev;
  logic sdiQ;

  // One sampling stage, then a history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      csNQ     <= 1'b1;
      csNPrev  <= 1'b1;
      sdiQ     <= 1'b0;
    end else begin
      sclkQ    <= sclk;
      sclkPrev <= sclkQ;
      csNQ     <= csN;
      csNPrev  <= csNQ;
      sdiQ     <= sdi;
    end
  end

  always_comb begin
    strobes.shiftEn   = sclkQ & ~sclkPrev & ~csNQ;
    strobes.outUpdate = ~sclkQ & sclkPrev & ~csNQ;
    strobes.latchLoad = csNQ & ~csNPrev;
  end

  assign sdiBit = sdiQ;

endmodule

// File: rtl/serialWiperDatapath.sv
module serialWiperDatapath
  import serialWiperPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wiperStrobes_t     strobes,
  input  logic              sdiBit,
  output logic [CODE_W-1:0] wiperCode,
  output logic              sdoBit
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= MID_CODE;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[CODE_W-2:0], sdiBit};
    end
  end

  // The output holds the register MSB from the last falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoBit <= MID_CODE[CODE_W-1];
    end else if (strobes.outUpdate) begin
      sdoBit <= shiftReg[CODE_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperCode <= MID_CODE;
    end else if (strobes.latchLoad) begin
      wiperCode <= shiftReg;
    end
  end

endmodule

// File: rtl/serialWiperTapDecoder.sv
module serialWiperTapDecoder #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0]      code,
  output logic [(1<<CODE_W)-1:0] tapSel
);

  localparam int TAP_COUNT = 1 << CODE_W;

  for (genvar tapIdx = 0; tapIdx < TAP_COUNT; tapIdx++) begin : g_tap
    assign tapSel[tapIdx] = (code == CODE_W'(tapIdx));
  end

endmodule

// File: rtl/serialWiperTop.sv
module serialWiperTop
  import serialWiperPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   sdi,
  output logic                   sdoPullDn,
  output logic                   sdoLevel,
  output logic [CODE_W-1:0]      wiperCode,
  output logic [(1<<CODE_W)-1:0] tapSel
);

  wiperStrobes_t strobes;
  logic          sdiBit;
  logic          sdoBit;

  serialWiperCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .sdi     (sdi),
    .strobes (strobes),
    .sdiBit  (sdiBit)
  );

  serialWiperDatapath #(.CODE_W(CODE_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sdiBit    (sdiBit),
    .wiperCode (wiperCode),
    .sdoBit    (sdoBit)
  );

  serialWiperTapDecoder #(.CODE_W(CODE_W)) u_decoder (
    .code   (wiperCode),
    .tapSel (tapSel)
  );

  // Open-drain model: pull low for a 0, release for a 1 (external pull-up).
  assign sdoPullDn = ~sdoBit;
  assign sdoLevel  = ~sdoPullDn;

endmodule

// File: rtl/serialWiperChecker.sv
module serialWiperChecker #(
  parameter int CODE_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclk,
  input logic                   csN,
  input logic                   sdoLevel,
  input logic [CODE_W-1:0]      wiperCode,
  input logic [(1<<CODE_W)-1:0] tapSel
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  // Independent view of the pin history.
  logic csD1, csD2, sclkD1, sclkD2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD1 <= 1'b1; csD2 <= 1'b1; sclkD1 <= 1'b0; sclkD2 <= 1'b0;
    end else begin
      csD1 <= csN; csD2 <= csD1; sclkD1 <= sclk; sclkD2 <= sclkD1;
    end
  end

  // R5: exactly one tap line, at the code index
  a_r5_one_tap: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tapSel) == 1) && tapSel[wiperCode]);

  // R2: the code moves only right after a select rise
  a_r2_load_on_select_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiperCode) |-> $past(csD1 && !csD2));

  // R4: reset gives the midscale code
  a_r4_reset_midscale: assert property (@(posedge clk)
    !rstN |=> (wiperCode == MID_CODE));

  // R6 / R8: the serial output moves only after a selected falling edge
  a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoLevel) |-> $past(sclkD2 && !sclkD1 && !csD1));

endmodule

bind serialWiperTop serialWiperChecker #(.CODE_W(CODE_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sclk      (sclk),
  .csN       (csN),
  .sdoLevel  (sdoLevel),
  .wiperCode (wiperCode),
  .tapSel    (tapSel)
);

// File: tb/serialWiperTop_bench.sv
module serialWiperTop_bench;

  localparam int CODE_W = 8;
  localparam int TAPS   = 1 << CODE_W;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic sdoPullDn, sdoLevel;
  logic [CODE_W-1:0] wiperCode;
  logic [TAPS-1:0]   tapSel;
  logic farPullDn, farLevel;
  logic [CODE_W-1:0] farCode;
  logic [TAPS-1:0]   farTapSel;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  serialWiperTop #(.CODE_W(CODE_W)) u_serialWiperTop (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .sdoPullDn(sdoPullDn), .sdoLevel(sdoLevel),
    .wiperCode(wiperCode), .tapSel(tapSel)
  );

  // Second device in the chain, fed from the first one's output.
  serialWiperTop #(.CODE_W(CODE_W)) u_serialWiperTopFar (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdoLevel),
    .sdoPullDn(farPullDn), .sdoLevel(farLevel),
    .wiperCode(farCode), .tapSel(farTapSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clockBit(input logic b);
    sdi = b;
    waitHalf();
    sclk = 1'b1;
    waitHalf();
    sclk = 1'b0;
    waitHalf();
  endtask

  task automatic sendBits(input logic [31:0] word, input int nBits);
    csN = 1'b0;
    waitHalf();
    for (int i = nBits - 1; i >= 0; i--) clockBit(word[i]);
    csN = 1'b1;
    waitHalf();
  endtask

  task automatic checkTap(input string req, input int code);
    check(req, $countones(tapSel), 1);
    check(req, int'(tapSel[code]), 1);
  endtask

  task automatic testReset();
    check("R4 code", int'(wiperCode), 'h80);
    checkTap("R4/R5 tap", 'h80);
    check("R4 sdoLevel", int'(sdoLevel), 1);
    check("R4 pullDn", int'(sdoPullDn), 0);
    // The first eight output bits after reset come from the preset 0x80.
    csN = 1'b0;
    waitHalf();
    clockBit(1'b0);
    check("R4 first out bit", int'(sdoLevel), 0);
    for (int i = 0; i < 7; i++) clockBit(1'b0);
    csN = 1'b1;
    waitHalf();
  endtask

  task automatic testWrites();
    sendBits(32'h3C, 8);
    check("R1 code 0x3C", int'(wiperCode), 'h3C);
    checkTap("R5 tap 0x3C", 'h3C);
    sendBits(32'h00, 8);
    check("R5 code 0x00", int'(wiperCode), 'h00);
    checkTap("R5 tap B end", 0);
    sendBits(32'hFF, 8);
    check("R5 code 0xFF", int'(wiperCode), 'hFF);
    checkTap("R5 tap last", 255);
    sendBits(32'h81, 8);
    check("R1 MSB first", int'(wiperCode), 'h81);
  endtask

  task automatic testLongWord();
    sendBits(32'hF5A, 12);
    check("R3 last eight", int'(wiperCode), 'h5A);
    sendBits(32'h2_C3, 10);
    check("R3 ten bits", int'(wiperCode), 'hC3);
  endtask

  task automatic testIgnoreAndEmpty();
    logic lvl;
    sendBits(32'hA5, 8);
    lvl = sdoLevel;
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      waitHalf(); sclk = 1'b1; waitHalf(); sclk = 1'b0; waitHalf();
    end
    check("R8 code", int'(wiperCode), 'hA5);
    check("R8 sdo unchanged", int'(sdoLevel), int'(lvl));
    csN = 1'b0;
    waitHalf();
    csN = 1'b1;
    waitHalf();
    check("R9 empty window reload", int'(wiperCode), 'hA5);
    check("R8 register unchanged", int'(wiperCode), 'hA5);
  endtask

  task automatic testChain();
    logic [15:0] frame = 16'h5AC3;
    int prev = int'(wiperCode);
    csN = 1'b0;
    waitHalf();
    for (int k = 1; k <= 16; k++) begin
      clockBit(frame[16 - k]);
      if (k >= 8) begin
        check("R6 chain out", int'(sdoLevel), int'(frame[16 - (k - 7)]));
        check("R7 pull-down", int'(sdoPullDn), int'(!frame[16 - (k - 7)]));
      end
      if (k == 12) check("R2 hold mid-frame", int'(wiperCode), prev);
    end
    csN = 1'b1;
    waitHalf();
    check("R6 near byte", int'(wiperCode), 'hC3);
    check("R6 far byte", int'(farCode), 'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    fork
      begin
        testReset();
        testWrites();
        testLongWord();
        testIgnoreAndEmpty();
        testChain();
      end
      begin
        repeat (150000) @(posedge clk);
        failCount++;
        checkCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule